// File: doc/BRIEF.md
# Latched Parallel-In Serial-Out Shifter

This block gathers a word of parallel inputs and sends it out one bit at a time, the way an input expander does on a serial peripheral bus. A capture strobe copies the parallel word into a holding register. That register is separate from the shift chain, so a fresh sample can be taken while an older word is still being clocked out. A mode input chooses what the chain does. When the mode is low, the chain copies the holding register on every cycle. When the mode is high, the chain shifts once on each rising edge of a shift strobe, taking the serial input in at its first stage. The last stage drives the serial output. An active-low enable qualifies that output.

Both strobes are sampled in the system clock domain, and only their rising edges act. The three-state output appears as a data bit and a separate drive-enable flag, which the pad ring or the bus fabric uses to turn the driver on. A reset that is synchronous and active high clears all storage.

Top module: `latched_piso`

## Requirements
- R1: A rising edge of `cap_stb` loads `par_in` into the holding register. This happens whatever the levels of `shift_mode` and `shift_stb` are.
- R2: While `shift_mode` is 0, the shift chain takes the holding register value on every clock, and `shift_stb` has no effect.
- R3: While `shift_mode` is 0, a `cap_stb` rising edge puts the new `par_in` into the holding register and the chain in the same cycle. `ser_out` then equals `par_in[W-1]`.
- R4: While `shift_mode` is 1, each `shift_stb` rising edge moves `ser_in` into chain bit 0, moves every bit k into bit k+1, and drops the old bit W-1.
- R5: `ser_in` has no effect while `shift_mode` is 0.
- R6: `ser_out` is always chain bit W-1. After a transfer, `par_in[W-1]` leaves first and `par_in[0]` leaves last, after W-1 shifts.
- R7: `ser_oe` is 1 exactly when `out_en_n` is 0. `out_en_n` never changes the holding register or the chain.
- R8: While `shift_mode` is 1, a `cap_stb` edge and a `shift_stb` edge in the same cycle both take effect.
- R9: While `shift_mode` is 1 and neither strobe rises, the holding register and the chain keep their values.
- R10: While `rst` is 1, the holding register and the chain clear to zero, so `ser_out` is 0.
- R11: A strobe held high for several cycles counts as a single edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_in | input | W | Parallel sample word; bit W-1 leaves first |
| cap_stb | input | 1 | Capture strobe; its rising edge loads the holding register |
| shift_stb | input | 1 | Shift strobe; its rising edge shifts when the mode is 1 |
| shift_mode | input | 1 | 0 = chain copies the holding register, 1 = chain shifts |
| ser_in | input | 1 | Serial cascade input into chain bit 0 |
| out_en_n | input | 1 | Active-low output enable |
| ser_out | output | 1 | Chain bit W-1 |
| ser_oe | output | 1 | Drive enable for ser_out |

## Verification
Each strobe edge takes effect at the first clock edge after the strobe goes high, because the edge detector and the storage update on that same edge. In copy mode the chain follows a plain holding-register change one clock later. `ser_oe` follows `out_en_n` with no delay. The bench drives every input on the falling edge and steps a reference model at the following rising edge. It compares `ser_out` and `ser_oe` 2 ns after that edge. Bit order and register contents are checked by shifting whole words out and comparing every bit.

// File: rtl/lpiso_pkg.sv
package lpiso_pkg;
  localparam int unsigned LPISO_W = 8;

  typedef enum logic {
    MODE_XFER  = 1'b0,
    MODE_SHIFT = 1'b1
  } chain_mode_e;
endpackage

// File: rtl/strobe_rise.sv
module strobe_rise (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  output logic rise
);
  logic stb_q;

  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= stb;
  end

  assign rise = stb & ~stb_q;

  // R11: a held strobe produces no second edge
  AST_HELD_ONE_EDGE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R11
endmodule

// File: rtl/hold_latch.sv
module hold_latch #(
  parameter int unsigned W = lpiso_pkg::LPISO_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (cap) q <= d;
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(q)); // R1
endmodule

// File: rtl/stage_chain.sv
module stage_chain
  import lpiso_pkg::*;
#(
  parameter int unsigned W = LPISO_W
) (
  input  logic         clk,
  input  logic         rst,
  input  chain_mode_e  mode,
  input  logic         cap_rise,
  input  logic         shift_rise,
  input  logic         ser_in,
  input  logic [W-1:0] par_in,
  input  logic [W-1:0] hold_q,
  output logic [W-1:0] stages
);
  logic [W-1:0] nxt;

  // shift path: stage 0 takes the serial input, the rest take their neighbour
  assign nxt[0] = ser_in;
  for (genvar k = 1; k < W; k++) begin : g_link
    assign nxt[k] = stages[k-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stages <= '0;
    end else if (mode == MODE_XFER) begin
      stages <= cap_rise ? par_in : hold_q;
    end else if (shift_rise) begin
      stages <= nxt;
    end
  end

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SHIFT && !shift_rise) |=> $stable(stages)); // R9
endmodule

// File: rtl/latched_piso.sv
module latched_piso
  import lpiso_pkg::*;
#(
  parameter int unsigned W = LPISO_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] par_in,
  input  logic         cap_stb,
  input  logic         shift_stb,
  input  logic         shift_mode,
  input  logic         ser_in,
  input  logic         out_en_n,
  output logic         ser_out,
  output logic         ser_oe
);
  logic         cap_rise;
  logic         shift_rise;
  logic [W-1:0] hold_q;
  logic [W-1:0] chain_q;
  chain_mode_e  mode;

  assign mode = chain_mode_e'(shift_mode);

  strobe_rise u_cap_edge (
    .clk (clk), .rst (rst), .stb (cap_stb), .rise (cap_rise)
  );

  strobe_rise u_shift_edge (
    .clk (clk), .rst (rst), .stb (shift_stb), .rise (shift_rise)
  );

  hold_latch #(.W(W)) u_hold (
    .clk (clk), .rst (rst), .cap (cap_rise), .d (par_in), .q (hold_q)
  );

  stage_chain #(.W(W)) u_chain (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .cap_rise   (cap_rise),
    .shift_rise (shift_rise),
    .ser_in     (ser_in),
    .par_in     (par_in),
    .hold_q     (hold_q),
    .stages     (chain_q)
  );

  assign ser_out = chain_q[W-1];
  assign ser_oe  = ~out_en_n;

  AST_XFER_TRACK: assert property (@(posedge clk) disable iff (rst)
    (!shift_mode && !cap_rise) |=> (ser_out == $past(hold_q[W-1]))); // R2
  AST_XFER_NEW: assert property (@(posedge clk) disable iff (rst)
    (!shift_mode && cap_rise) |=> (ser_out == $past(par_in[W-1]))); // R3
  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
    (shift_mode && shift_rise) |=> (ser_out == $past(chain_q[W-2]))); // R4
endmodule

// File: tb/latched_piso_tb.sv
module latched_piso_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] par_in;
  logic         cap_stb, shift_stb, shift_mode, ser_in, out_en_n;
  logic         ser_out, ser_oe;

  int total = 0;
  int bad   = 0;

  logic [W-1:0] m_hold, m_chain;
  logic         m_cap_prev, m_sh_prev;

  always #5 clk = ~clk;

  latched_piso #(.W(W)) u_dut (
    .clk (clk), .rst (rst), .par_in (par_in), .cap_stb (cap_stb),
    .shift_stb (shift_stb), .shift_mode (shift_mode), .ser_in (ser_in),
    .out_en_n (out_en_n), .ser_out (ser_out), .ser_oe (ser_oe)
  );

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one clock: drive on the falling edge, step the model at the rising edge, compare 2 ns later
  task automatic cyc(string tag, logic cap, logic sh, logic mode,
                     logic sin, logic [W-1:0] par, logic oen);
    logic cr, sr;
    @(negedge clk);
    cap_stb = cap; shift_stb = sh; shift_mode = mode;
    ser_in = sin; par_in = par; out_en_n = oen;
    @(posedge clk);
    if (rst) begin
      m_hold = '0; m_chain = '0; m_cap_prev = 1'b0; m_sh_prev = 1'b0;
    end else begin
      cr = cap & ~m_cap_prev;
      sr = sh & ~m_sh_prev;
      if (!mode)   m_chain = cr ? par : m_hold;
      else if (sr) m_chain = {m_chain[W-2:0], sin};
      if (cr) m_hold = par;
      m_cap_prev = cap; m_sh_prev = sh;
    end
    #2;
    check({tag, " ser_out"}, ser_out, m_chain[W-1]);
    check({tag, " ser_oe"},  ser_oe,  ~oen);
  endtask

  // clock the whole chain out with mode 1, comparing every bit
  task automatic drain(string tag, logic sin);
    for (int i = 0; i < W; i++) begin
      cyc(tag, 1'b0, 1'b1, 1'b1, sin, 8'h00, 1'b0);
      cyc(tag, 1'b0, 1'b0, 1'b1, sin, 8'h00, 1'b0);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cyc("R10 reset", 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF, 1'b0);
    cyc("R10 reset", 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0);
    rst = 1'b0;
    cyc("R10 after reset", 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 1'b0);
    check("R10 ser_out zero", ser_out, 1'b0);
  endtask

  task automatic t_transfer();
    cyc("R3 load both", 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0);
    check("R3 ser_out is par_in[W-1]", ser_out, 1'b1);
    cyc("R3 hold", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    drain("R6 order", 1'b0);
    drain("R4 ser_in", 1'b1);
  endtask

  task automatic t_latch_only();
    cyc("R1 seed", 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b0);
    cyc("R1 seed", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    cyc("R1 capture in shift mode", 1'b1, 1'b0, 1'b1, 1'b1, 8'hC9, 1'b0);
    for (int i = 0; i < 3; i++)
      cyc("R9 hold", 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
    drain("R9 chain kept", 1'b0);
    cyc("R2 copy", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    drain("R1 latch content", 1'b0);
  endtask

  task automatic t_ignore();
    cyc("R2 seed", 1'b1, 1'b0, 1'b0, 1'b1, 8'h96, 1'b0);
    for (int i = 0; i < 6; i++)
      cyc("R5 ignored", 1'b0, i[0], 1'b0, ~i[0], 8'h00, 1'b0);
    drain("R2 unchanged", 1'b0);
  endtask

  task automatic t_simul();
    cyc("R8 seed", 1'b1, 1'b0, 1'b0, 1'b0, 8'h81, 1'b0);
    cyc("R8 seed", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    cyc("R8 both edges", 1'b1, 1'b1, 1'b1, 1'b1, 8'h5A, 1'b0);
    cyc("R8 release", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    drain("R8 shifted", 1'b0);
    cyc("R8 copy", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    drain("R8 latched", 1'b0);
  endtask

  task automatic t_oe();
    cyc("R7 disabled load", 1'b1, 1'b0, 1'b0, 1'b0, 8'hE7, 1'b1);
    check("R7 oe low", ser_oe, 1'b0);
    cyc("R7 disabled", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1);
    cyc("R7 disabled shift", 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1);
    cyc("R7 enabled", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    check("R7 oe high", ser_oe, 1'b1);
    drain("R7 content", 1'b0);
  endtask

  task automatic t_held();
    cyc("R11 first", 1'b1, 1'b0, 1'b0, 1'b0, 8'h0F, 1'b0);
    cyc("R11 held", 1'b1, 1'b0, 1'b0, 1'b0, 8'hF0, 1'b0);
    cyc("R11 held", 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0);
    check("R11 held strobe ignored", ser_out, 1'b0);
    cyc("R11 low", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    cyc("R11 shift held", 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
    cyc("R11 shift held", 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
    cyc("R11 shift held", 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
    drain("R11 content", 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; par_in = '0; cap_stb = 1'b0; shift_stb = 1'b0;
    shift_mode = 1'b0; ser_in = 1'b0; out_en_n = 1'b0;
    m_hold = '0; m_chain = '0; m_cap_prev = 1'b0; m_sh_prev = 1'b0;
    t_reset();
    t_transfer();
    t_latch_only();
    t_ignore();
    t_simul();
    t_oe();
    t_held();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule